// File: doc/BRIEF.md
# Programmable Timing Table Sequencer

This block walks a small table of timing rows to run one conversion frame. Each row holds sixteen control flags and a sixteen-bit hold count. When a start-conversion pulse is sampled while the sequencer is idle and armed, row 0 is loaded. The sequencer then steps through the rows in order. Each row's flags appear together on the output bus for a programmed number of clocks. The frame ends after the first row that carries the end-of-cycle flag. The flags drive analog front-end actions such as amplifier reset, sampling, ramp control and conversion enable, plus a ready pulse that tells a frame buffer to capture. Here those actions are only output bits.

The table comes out of reset with default contents and can be read or rewritten one byte at a time through a plain register port. A control/status byte sits just above the table. Reading it gives the busy state and a pending-abort bit. Writing it with bit 0 set starts a self-clearing abort. None of the block's interfaces carries a data stream, so every pin is a plain level or strobe with no handshake.

Top module: `tts_sequencer`

## Requirements
- R1: After reset, `seq_flags` is all zero, `seq_busy` is low and the status byte reads 0. The table holds a default frame whose conversion row is row 6 and whose end-of-cycle row is row 9. While the sequencer is idle, `seq_flags` stays zero.
- R2: Row r occupies byte addresses 4r..4r+3. Offset 0 holds flags[7:0], offset 1 holds flags[15:8], offset 2 holds hold[7:0] and offset 3 holds hold[15:8]. Flag bit 11 is the ready pulse and flag bit 12 is end-of-cycle.
- R3: When `conv_start` is high at a rising edge while the sequencer is idle and armed, `busy` rises after that edge and `seq_flags` shows row 0's flags after that same edge.
- R4: A row is shown for hold+1 clocks, and a hold of 0 counts as 1, so every row lasts at least 2 clocks. Rows follow in increasing order.
- R5: The frame ends after the hold of the first row with bit 12 set. Row 31 also ends the frame if no earlier row has bit 12 set. After that row, `seq_flags` returns to zero and `busy` drops.
- R6: `conv_start` is ignored on the first 200 rising edges after reset is released. From edge 201 on, it is accepted.
- R7: Writing a byte with bit 0 set to address 0x80 sets the pending-abort status bit (bit 1). On the next edge, the frame stops, `seq_flags` goes to zero, `busy` drops and the pending bit clears by itself.
- R8: A `conv_start` that arrives while a frame is running has no effect on the row sequence.
- R9: Bit 0 of the status byte at address 0x80 reads 1 while a frame is running.
- R10: The default conversion row hold equals 2^N/16 − 8 for resolution N bits. At the default N = 14, this is 1016.
- R11: Any table byte written through the port reads back unchanged, and the next frame uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Start-conversion request, sampled at the rising edge |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address (table 0x00–0x7F, control/status 0x80) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr`, combinational |
| seq_flags | output | 16 | Control flags of the current row, zero when idle |
| seq_busy | output | 1 | High while a frame is running |

## Verification
The bench goes after the arming boundary by holding a start high across edges 200 and 201. A guard that is off by one would start the frame one edge early or one edge late. Rows with a hold of 0 and of 1 both check the two-clock minimum. A design that took a hold of 0 literally would show such a row for one clock and shift every later row. A table with no end-of-cycle row checks termination at row 31, which a wrapping pointer would miss by looping forever. The remaining cases are a start pulse in the middle of a frame and an abort in the middle of a row. The first would restart the frame if start were not gated by busy. The second would leave flags driven or the pending bit stuck if the abort path were wrong.

// File: rtl/tts_pkg.sv
package tts_pkg;
  localparam int FLAG_W  = 16;
  localparam int HOLD_W  = 16;
  localparam int WORD_W  = FLAG_W + HOLD_W;

  // flag bit positions (bit 11 ready and bit 12 end-of-cycle are decoded)
  localparam int F_AMP_RST  = 0;
  localparam int F_CMP_RST  = 1;
  localparam int F_OFS_SMP  = 2;
  localparam int F_SIG_SMP  = 3;
  localparam int F_RMP_RST  = 4;
  localparam int F_RMP_END  = 5;
  localparam int F_SWAP     = 6;
  localparam int F_CMP_LRST = 7;
  localparam int F_FE_BIAS  = 8;
  localparam int F_CMP_BIAS = 9;
  localparam int F_CONV_EN  = 10;
  localparam int F_READY    = 11;
  localparam int F_EOC      = 12;

  function automatic logic [FLAG_W-1:0] fbit(input int idx);
    return FLAG_W'(1) << idx;
  endfunction

  // default row word: {hold, flags}
  function automatic logic [WORD_W-1:0] dflt_row(input int r, input int conv_hold);
    logic [FLAG_W-1:0] f;
    logic [HOLD_W-1:0] h;
    logic [FLAG_W-1:0] pre;
    pre = fbit(F_FE_BIAS) | fbit(F_CMP_BIAS) | fbit(F_CMP_RST) |
          fbit(F_CMP_LRST) | fbit(F_RMP_RST) | fbit(F_SWAP);
    case (r)
      0: begin f = pre;                                  h = 16'd2; end
      1: begin f = pre | fbit(F_SIG_SMP);                h = 16'd8; end
      2: begin f = pre | fbit(F_AMP_RST);                h = 16'd4; end
      3: begin f = pre | fbit(F_OFS_SMP);                h = 16'd6; end
      4: begin f = fbit(F_CMP_BIAS) | fbit(F_CMP_LRST) | fbit(F_RMP_RST); h = 16'd2; end
      5: begin f = fbit(F_CMP_BIAS) | fbit(F_CMP_LRST);  h = 16'd2; end
      6: begin f = fbit(F_CMP_BIAS) | fbit(F_CONV_EN);   h = HOLD_W'(conv_hold); end
      7: begin f = fbit(F_CMP_BIAS) | fbit(F_RMP_END);   h = 16'd3; end
      8: begin f = fbit(F_READY) | fbit(F_RMP_RST);      h = 16'd1; end
      9: begin f = fbit(F_EOC);                          h = 16'd1; end
      default: begin f = '0; h = '0; end
    endcase
    return {h, f};
  endfunction
endpackage

// File: rtl/tts_table.sv
module tts_table
  import tts_pkg::*;
#(
  parameter int ROWS     = 32,
  parameter int RES_BITS = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(ROWS)-1:0]  wr_row,
  input  logic [1:0]               wr_lane,
  input  logic [7:0]               wr_byte,
  input  logic [$clog2(ROWS)-1:0]  seq_row,
  output logic [WORD_W-1:0]        seq_word,
  input  logic [$clog2(ROWS)-1:0]  port_row,
  input  logic [1:0]               port_lane,
  output logic [7:0]               port_byte
);
  localparam int CONV_HOLD = (1 << RES_BITS) / 16 - 8;

  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= dflt_row(r, CONV_HOLD);
    end else if (wr_en) begin
      mem[wr_row][8*wr_lane +: 8] <= wr_byte;
    end
  end

  assign seq_word  = mem[seq_row];
  assign port_byte = mem[port_row][8*port_lane +: 8];
endmodule

// File: rtl/tts_arm.sv
module tts_arm #(
  parameter int ARM_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);
  localparam int CW = $clog2(ARM_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ARM_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign armed = (cnt_q == LIMIT);

  p_arm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

// File: rtl/tts_engine.sv
module tts_engine
  import tts_pkg::*;
#(
  parameter int ROWS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    abort_i,
  input  logic [WORD_W-1:0]       row_word_i,
  output logic [$clog2(ROWS)-1:0] rd_row_o,
  output logic [FLAG_W-1:0]       flags_o,
  output logic                    busy_o
);
  localparam int RW = $clog2(ROWS);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic              busy_q;
  logic [RW-1:0]     row_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [FLAG_W-1:0] flags_q;
  logic [HOLD_W-1:0] eff_hold;
  logic              last_row;

  assign rd_row_o = busy_q ? row_q + 1'b1 : '0;
  assign eff_hold = (row_word_i[WORD_W-1:FLAG_W] == '0) ? HOLD_W'(1)
                                                        : row_word_i[WORD_W-1:FLAG_W];
  assign last_row = flags_q[F_EOC] || (row_q == LAST_ROW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; row_q <= '0; cnt_q <= '0; flags_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0; row_q <= '0; cnt_q <= '0; flags_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        row_q   <= '0;
        flags_q <= row_word_i[FLAG_W-1:0];
        cnt_q   <= eff_hold;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (last_row) begin
      busy_q  <= 1'b0;
      row_q   <= '0;
      flags_q <= '0;
    end else begin
      row_q   <= row_q + 1'b1;
      flags_q <= row_word_i[FLAG_W-1:0];
      cnt_q   <= eff_hold;
    end
  end

  assign flags_o = flags_q;
  assign busy_o  = busy_q;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> flags_q == '0);
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_i && !abort_i) |=> (busy_q && row_q == '0));
  p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && row_q != $past(row_q)) |-> cnt_q != '0);
  p_eoc_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0 && flags_q[F_EOC] && !abort_i) |=> !busy_q);
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_q && flags_q == '0));
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !abort_i && cnt_q != '0) |=> (busy_q && row_q == $past(row_q)));
endmodule

// File: rtl/tts_sequencer.sv
module tts_sequencer
  import tts_pkg::*;
#(
  parameter int ROWS       = 32,
  parameter int RES_BITS   = 14,
  parameter int ARM_CYCLES = 200,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [FLAG_W-1:0] seq_flags,
  output logic              seq_busy
);
  localparam int RW = $clog2(ROWS);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(ROWS * 4);

  logic              armed;
  logic              abort_pend;
  logic              tbl_hit;
  logic              ctl_hit;
  logic [RW-1:0]     seq_row;
  logic [WORD_W-1:0] seq_word;
  logic [7:0]        tbl_byte;

  assign tbl_hit = cfg_addr < CTL_ADDR;
  assign ctl_hit = cfg_addr == CTL_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_pend <= 1'b0;
    else        abort_pend <= cfg_we && ctl_hit && cfg_wdata[0];
  end

  tts_arm #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk(clk), .rst_n(rst_n), .armed(armed)
  );

  tts_table #(.ROWS(ROWS), .RES_BITS(RES_BITS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && tbl_hit), .wr_row(cfg_addr[RW+1:2]), .wr_lane(cfg_addr[1:0]),
    .wr_byte(cfg_wdata),
    .seq_row(seq_row), .seq_word(seq_word),
    .port_row(cfg_addr[RW+1:2]), .port_lane(cfg_addr[1:0]), .port_byte(tbl_byte)
  );

  tts_engine #(.ROWS(ROWS)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_i(conv_start && armed), .abort_i(abort_pend),
    .row_word_i(seq_word), .rd_row_o(seq_row),
    .flags_o(seq_flags), .busy_o(seq_busy)
  );

  always_comb begin
    if (tbl_hit)      cfg_rdata = tbl_byte;
    else if (ctl_hit) cfg_rdata = {6'b0, abort_pend, seq_busy};
    else              cfg_rdata = '0;
  end

  p_arm_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !seq_busy);
  p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pend && !(cfg_we && ctl_hit)) |=> !abort_pend);
endmodule

// File: tb/tts_sequencer_bench.sv
module tts_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] seq_flags;
  logic        seq_busy;

  int total = 0;
  int bad = 0;
  int ecount = 0;
  bit done = 0;
  bit mon_en = 0;
  string cur_req = "R4";
  logic [16:0] sb_q[$];
  logic [15:0] mf [32];
  logic [15:0] md [32];

  always #10 clk = ~clk;

  tts_sequencer u_tts_sequencer (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .seq_flags(seq_flags), .seq_busy(seq_busy)
  );

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en && sb_q.size() > 0) begin
      logic [16:0] e;
      e = sb_q.pop_front();
      chk({seq_busy, seq_flags} == e, cur_req, {15'b0, seq_busy, seq_flags}, {15'b0, e});
    end
  end

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic put_row(input int r, input logic [15:0] f, input logic [15:0] h);
    wr(8'(4*r + 0), f[7:0]);
    wr(8'(4*r + 1), f[15:8]);
    wr(8'(4*r + 2), h[7:0]);
    wr(8'(4*r + 3), h[15:8]);
    mf[r] = f; md[r] = h;
  endtask

  // driver: start a frame and push the expected per-cycle outputs
  task automatic run_frame(input int poke_at);
    @(negedge clk);
    conv_start = 1'b1;
    @(posedge clk);
    #1 conv_start = 1'b0;
    for (int r = 0; r < 32; r++) begin
      int eff;
      eff = (md[r] == 16'd0) ? 1 : int'(md[r]);
      repeat (eff + 1) sb_q.push_back({1'b1, mf[r]});
      if (mf[r][12]) break;
    end
    sb_q.push_back(17'h0);
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      conv_start = 1'b1;
      cfg_addr = 8'h80;
      #1 chk(cfg_rdata[0] == 1'b1, "R9", {24'b0, cfg_rdata}, 32'h1);
      @(posedge clk);
      #1 conv_start = 1'b0;
    end
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk(seq_flags == 16'h0 && !seq_busy, "R1", {15'b0, seq_busy, seq_flags}, 32'h0);
    rd(8'h80, b); chk(b == 8'h00, "R1", {24'b0, b}, 32'h0);
    rd(8'h1A, b); chk(b == 8'hF8, "R10", {24'b0, b}, 32'hF8);
    rd(8'h1B, b); chk(b == 8'h03, "R10", {24'b0, b}, 32'h03);
    rd(8'h25, b); chk(b[4] == 1'b1, "R1", {24'b0, b}, 32'h10);

    // R6 early start ignored
    @(negedge clk) conv_start = 1'b1;
    @(posedge clk) #1 conv_start = 1'b0;
    @(negedge clk);
    chk(!seq_busy, "R6", {31'b0, seq_busy}, 32'h0);

    // R6 boundary: start held across edges 200 and 201
    while (ecount < 199) @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    chk(!seq_busy, "R6", {31'b0, seq_busy}, 32'h0);
    @(negedge clk);
    chk(seq_busy, "R6", {31'b0, seq_busy}, 32'h1);
    chk(seq_flags != 16'h0, "R3", {16'b0, seq_flags}, 32'h1);
    conv_start = 1'b0;

    // R7 abort mid-frame
    repeat (4) @(negedge clk);
    wr(8'h80, 8'h01);
    chk(cfg_rdata[1] == 1'b1 && seq_busy, "R7", {24'b0, cfg_rdata}, 32'h3);
    @(posedge clk);
    #1;
    chk(!seq_busy && seq_flags == 16'h0, "R7", {15'b0, seq_busy, seq_flags}, 32'h0);
    chk(cfg_rdata == 8'h00, "R7", {24'b0, cfg_rdata}, 32'h0);

    // read default table into model through the port
    for (int a = 0; a < 128; a++) begin
      rd(8'(a), b);
      case (a % 4)
        0: mf[a/4][7:0]  = b;
        1: mf[a/4][15:8] = b;
        2: md[a/4][7:0]  = b;
        default: md[a/4][15:8] = b;
      endcase
    end
    chk(md[6] == 16'd1016, "R10", {16'b0, md[6]}, 32'd1016);

    // default frame with a start poke mid-frame (R3 R4 R5 R8 R9)
    mon_en = 1'b1;
    cur_req = "R8";
    run_frame(5);

    // custom table: hold 0 and 1 rows, end-cycle at row 3 (R2 R4 R11)
    cur_req = "R4";
    put_row(0, 16'h0103, 16'd0);
    put_row(1, 16'h0410, 16'd1);
    put_row(2, 16'h0808, 16'd5);
    put_row(3, 16'h1800, 16'd0);
    put_row(4, 16'h00FF, 16'd3);
    rd(8'h0A, b); chk(b == 8'd5, "R11", {24'b0, b}, 32'd5);
    rd(8'h05, b); chk(b == 8'h04, "R2", {24'b0, b}, 32'h04);
    run_frame(0);

    // no end-cycle row anywhere: frame stops after row 31 (R5)
    cur_req = "R5";
    for (int r = 0; r < 32; r++) put_row(r, 16'(r + 1), 16'd0);
    run_frame(0);
    repeat (3) @(negedge clk);
    chk(!seq_busy && seq_flags == 16'h0, "R5", {15'b0, seq_busy, seq_flags}, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule